// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block sequences a small single-bus processor through instruction fetch and execution. A step counter, cleared at reset and at the end of every instruction, feeds a one-hot step decoder. In parallel, an opcode decoder turns the instruction register's operation field into one-hot instruction lines. A fixed set of product-term equations combines step lines, instruction lines and the zero flag to drive each datapath enable, the memory read request, the ALU function code and the wait-for-memory and end-of-instruction strobes.

Every instruction starts with a shared three-step fetch. For ALU instructions, a memory operand is then added to, subtracted from or XORed with register R1. For a branch, the instruction's offset field is added to the PC through Y and Z. While the unit waits for memory the step counter holds. The same happens when the external run enable is low.

Top module: `hwctl_unit`

## Requirements
- R1: While rst_n is low the unit sits at step T1 and drives the first fetch step's controls.
- R2: At T1 the unit asserts pc_out, mar_in, mem_rd, clr_y, carry_in and z_in with alu_op = 4'b0000, and every other enable, wmfc and end_step are low.
- R3: At T2 only z_out, pc_in and wmfc are asserted. At T3 only mdr_out and ir_in are asserted.
- R4: When run_en is low the step does not change. When run_en is high and there is no memory wait and no end of instruction, the step advances by one per clock.
- R5: When wmfc is asserted and mfc is low, the step holds. When mfc is high in that step, the step advances.
- R6: The ALU instructions are ADD = 4'h1, SUB = 4'h2 and XOR = 4'h3. Their execute sequence is: T4 src_out, mar_in, mem_rd. T5 r1_out, y_in, wmfc. T6 mdr_out, z_in. T7 z_out, r1_in, end_step.
- R7: At T6 of an ALU instruction, alu_op is 4'b0000 for ADD, 4'b0001 for SUB and 4'b1111 for XOR. In all other steps alu_op is 4'b0000.
- R8: Branch (opcode 4'h4) runs T4 pc_out, y_in, then T5 off_out, z_in, then T6 z_out, pc_in, end_step.
- R9: Branch-if-zero (opcode 4'h5) follows the branch sequence when zero_flag is 1. When zero_flag is 0 it asserts only end_step at T4.
- R10: Any other opcode asserts only end_step at T4.
- R11: A step that asserts end_step while run_en is high is followed by step T1.
- R12: At most one of pc_out, mdr_out, z_out, src_out, r1_out and off_out is high in any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | External run enable for the step counter |
| ir_opc | input | 4 | Opcode field of the instruction register |
| mfc | input | 1 | Memory function complete |
| zero_flag | input | 1 | Zero condition flag |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | Memory address register loads |
| mdr_out | output | 1 | Memory data register drives the bus |
| ir_in | output | 1 | Instruction register loads |
| y_in | output | 1 | Y register loads |
| z_in | output | 1 | Z register loads the ALU result |
| z_out | output | 1 | Z drives the bus |
| src_out | output | 1 | Source address register drives the bus |
| r1_out | output | 1 | R1 drives the bus |
| r1_in | output | 1 | R1 loads |
| off_out | output | 1 | Instruction offset field drives the bus |
| mem_rd | output | 1 | Memory read request |
| clr_y | output | 1 | Forces the Y operand to zero |
| carry_in | output | 1 | ALU carry input |
| alu_op | output | 4 | ALU function code |
| wmfc | output | 1 | Wait for memory function complete |
| end_step | output | 1 | Last step of the instruction |

## Verification
The assertions assume that ir_opc and zero_flag stay constant from T1 until end_step, because a real instruction register changes only at fetch. The stimulus picks a new opcode and flag only when the sequence is back at T1. The assertions also assume that mfc is meaningful only while wmfc is high. The bench drives mfc and run_en randomly, with run_en high most of the time, so that both the hold paths and the advance paths occur many times. Undefined opcodes and the untaken branch-if-zero case are included in the random opcode pool.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'h2;
  localparam logic [OPC_W-1:0] OPC_XOR = 4'h3;
  localparam logic [OPC_W-1:0] OPC_BR  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_BRZ = 4'h5;

  localparam int INS_ADD = 0;
  localparam int INS_SUB = 1;
  localparam int INS_XOR = 2;
  localparam int INS_BR  = 3;
  localparam int INS_BRZ = 4;
  localparam int N_INS   = 5;

  localparam int LAST_DEF_IDX = 6;  // T7 is the last step any instruction uses

  typedef enum logic [3:0] {
    ALU_ADD = 4'b0000,
    ALU_SUB = 4'b0001,
    ALU_XOR = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic    pc_out;
    logic    pc_in;
    logic    mar_in;
    logic    mdr_out;
    logic    ir_in;
    logic    y_in;
    logic    z_in;
    logic    z_out;
    logic    src_out;
    logic    r1_out;
    logic    r1_in;
    logic    off_out;
    logic    mem_rd;
    logic    clr_y;
    logic    carry_in;
    logic    wmfc;
    logic    end_step;
    alu_op_e alu_op;
  } ctl_word_t;

endpackage

// File: rtl/hwctl_step_ctr.sv
module hwctl_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wmfc,
  input  logic              mfc,
  input  logic              done,
  output logic [STEP_W-1:0] step
);

  logic              stall;
  logic              adv_en;
  logic [STEP_W-1:0] step_nxt;

  assign stall  = wmfc & ~mfc;
  assign adv_en = run_en & ~stall;

  always_comb begin
    step_nxt = step;
    if (adv_en) begin
      if (done) step_nxt = '0;
      else      step_nxt = step + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step <= '0;
    else if (adv_en) step <= step_nxt;
  end

  AST_HOLD_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(step)); // R4

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !done && !(wmfc && !mfc)) |=> step == $past(step) + STEP_W'(1)); // R4

  AST_HOLD_WMFC: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc && !mfc) |=> $stable(step)); // R5

  AST_END_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && done && !wmfc) |=> step == '0); // R11

endmodule

// File: rtl/hwctl_step_dec.sv
module hwctl_step_dec #(
  parameter int STEP_W  = 3,
  parameter int N_STEPS = 1 << STEP_W
) (
  input  logic [STEP_W-1:0]  step,
  output logic [N_STEPS-1:0] t
);

  for (genvar g = 0; g < N_STEPS; g++) begin : g_line
    assign t[g] = (step == STEP_W'(g));
  end

  always_comb begin
    AST_STEP_ONEHOT: assert ($onehot(t)); // R4
  end

endmodule

// File: rtl/hwctl_insn_dec.sv
module hwctl_insn_dec
  import hwctl_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output logic [N_INS-1:0] ins
);

  always_comb begin
    ins = '0;
    case (opc)
      OPC_ADD: ins[INS_ADD] = 1'b1;
      OPC_SUB: ins[INS_SUB] = 1'b1;
      OPC_XOR: ins[INS_XOR] = 1'b1;
      OPC_BR:  ins[INS_BR]  = 1'b1;
      OPC_BRZ: ins[INS_BRZ] = 1'b1;
      default: ins = '0;
    endcase
  end

  always_comb begin
    AST_INS_ONEHOT0: assert ($onehot0(ins)); // R10
  end

endmodule

// File: rtl/hwctl_encoder.sv
module hwctl_encoder
  import hwctl_pkg::*;
#(
  parameter int N_STEPS = 8
) (
  input  logic [N_STEPS-1:0] t,
  input  logic [N_INS-1:0]   ins,
  input  logic               zero_flag,
  output ctl_word_t          cw
);

  logic alu_grp;
  logic br_take;
  logic br_skip;
  logic no_ins;
  logic beyond;

  assign alu_grp = ins[INS_ADD] | ins[INS_SUB] | ins[INS_XOR];
  assign br_take = ins[INS_BR] | (ins[INS_BRZ] & zero_flag);
  assign br_skip = ins[INS_BRZ] & ~zero_flag;
  assign no_ins  = ~|ins;

  always_comb begin
    beyond = 1'b0;
    for (int i = LAST_DEF_IDX + 1; i < N_STEPS; i++) beyond = beyond | t[i];
  end

  always_comb begin
    cw.pc_out   = t[0] | (t[3] & br_take);
    cw.pc_in    = t[1] | (t[5] & br_take);
    cw.mar_in   = t[0] | (t[3] & alu_grp);
    cw.mem_rd   = t[0] | (t[3] & alu_grp);
    cw.clr_y    = t[0];
    cw.carry_in = t[0];
    cw.z_in     = t[0] | (t[5] & alu_grp) | (t[4] & br_take);
    cw.z_out    = t[1] | (t[6] & alu_grp) | (t[5] & br_take);
    cw.wmfc     = t[1] | (t[4] & alu_grp);
    cw.mdr_out  = t[2] | (t[5] & alu_grp);
    cw.ir_in    = t[2];
    cw.src_out  = t[3] & alu_grp;
    cw.r1_out   = t[4] & alu_grp;
    cw.y_in     = (t[4] & alu_grp) | (t[3] & br_take);
    cw.off_out  = t[4] & br_take;
    cw.r1_in    = t[6] & alu_grp;
    cw.end_step = (t[6] & alu_grp) | (t[5] & br_take)
                | (t[3] & (br_skip | no_ins)) | beyond;
    if (t[5] & ins[INS_SUB])      cw.alu_op = ALU_SUB;
    else if (t[5] & ins[INS_XOR]) cw.alu_op = ALU_XOR;
    else                          cw.alu_op = ALU_ADD;
  end

  always_comb begin
    AST_ONE_BUS_SOURCE: assert ($onehot0({cw.pc_out, cw.mdr_out, cw.z_out,
                                          cw.src_out, cw.r1_out, cw.off_out})); // R12
    AST_NO_WAIT_AT_END: assert (!(cw.wmfc && cw.end_step)); // R11
  end

endmodule

// File: rtl/hwctl_unit.sv
module hwctl_unit
  import hwctl_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [OPC_W-1:0] ir_opc,
  input  logic             mfc,
  input  logic             zero_flag,
  output logic             pc_out,
  output logic             pc_in,
  output logic             mar_in,
  output logic             mdr_out,
  output logic             ir_in,
  output logic             y_in,
  output logic             z_in,
  output logic             z_out,
  output logic             src_out,
  output logic             r1_out,
  output logic             r1_in,
  output logic             off_out,
  output logic             mem_rd,
  output logic             clr_y,
  output logic             carry_in,
  output logic [3:0]       alu_op,
  output logic             wmfc,
  output logic             end_step
);

  localparam int N_STEPS = 1 << STEP_W;

  logic [1:0]         rst_sync;
  logic               rst_core_n;
  logic [STEP_W-1:0]  step;
  logic [N_STEPS-1:0] t;
  logic [N_INS-1:0]   ins;
  ctl_word_t          cw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  hwctl_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_en (run_en),
    .wmfc   (cw.wmfc),
    .mfc    (mfc),
    .done   (cw.end_step),
    .step   (step)
  );

  hwctl_step_dec #(.STEP_W(STEP_W), .N_STEPS(N_STEPS)) u_sdec (
    .step (step),
    .t    (t)
  );

  hwctl_insn_dec u_idec (
    .opc (ir_opc),
    .ins (ins)
  );

  hwctl_encoder #(.N_STEPS(N_STEPS)) u_enc (
    .t         (t),
    .ins       (ins),
    .zero_flag (zero_flag),
    .cw        (cw)
  );

  assign pc_out   = cw.pc_out;
  assign pc_in    = cw.pc_in;
  assign mar_in   = cw.mar_in;
  assign mdr_out  = cw.mdr_out;
  assign ir_in    = cw.ir_in;
  assign y_in     = cw.y_in;
  assign z_in     = cw.z_in;
  assign z_out    = cw.z_out;
  assign src_out  = cw.src_out;
  assign r1_out   = cw.r1_out;
  assign r1_in    = cw.r1_in;
  assign off_out  = cw.off_out;
  assign mem_rd   = cw.mem_rd;
  assign clr_y    = cw.clr_y;
  assign carry_in = cw.carry_in;
  assign alu_op   = cw.alu_op;
  assign wmfc     = cw.wmfc;
  assign end_step = cw.end_step;

  AST_RESET_FETCH: assert property (@(posedge clk)
    !rst_n |-> (pc_out && mar_in && mem_rd && z_in && !end_step)); // R1

  AST_T1_AFTER_END: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en && end_step) |=> (pc_out && clr_y && carry_in)); // R11

endmodule

// File: tb/hwctl_unit_test.sv
module hwctl_unit_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic [3:0] ir_opc;
  logic       mfc;
  logic       zero_flag;
  logic pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, z_in, z_out;
  logic src_out, r1_out, r1_in, off_out, mem_rd, clr_y, carry_in;
  logic [3:0] alu_op;
  logic wmfc, end_step;

  int n_chk = 0;
  int n_bad = 0;
  int m_step = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwctl_unit uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ir_opc(ir_opc), .mfc(mfc),
    .zero_flag(zero_flag), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in),
    .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .z_in(z_in), .z_out(z_out),
    .src_out(src_out), .r1_out(r1_out), .r1_in(r1_in), .off_out(off_out),
    .mem_rd(mem_rd), .clr_y(clr_y), .carry_in(carry_in), .alu_op(alu_op),
    .wmfc(wmfc), .end_step(end_step)
  );

  function automatic logic [20:0] act_vec();
    return {pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, z_in, z_out, src_out,
            r1_out, r1_in, off_out, mem_rd, clr_y, carry_in, wmfc, end_step, alu_op};
  endfunction

  function automatic logic [20:0] exp_vec(int s, logic [3:0] op, logic z);
    logic pco, pci, mar, mdro, iri, yi, zi, zo, so, r1o, r1i, offo, rdd, cy, ci, wm, dn;
    logic [3:0] alu;
    logic is_alu, is_br;
    {pco, pci, mar, mdro, iri, yi, zi, zo, so, r1o, r1i, offo, rdd, cy, ci, wm, dn} = '0;
    alu = 4'b0000;
    is_alu = (op == 4'h1) || (op == 4'h2) || (op == 4'h3);
    is_br  = (op == 4'h4) || (op == 4'h5 && z);
    case (s)
      0: begin pco = 1; mar = 1; rdd = 1; cy = 1; ci = 1; zi = 1; end
      1: begin zo = 1; pci = 1; wm = 1; end
      2: begin mdro = 1; iri = 1; end
      3: if (is_alu) begin so = 1; mar = 1; rdd = 1; end
         else if (is_br) begin pco = 1; yi = 1; end
         else dn = 1;
      4: if (is_alu) begin r1o = 1; yi = 1; wm = 1; end
         else if (is_br) begin offo = 1; zi = 1; end
      5: if (is_alu) begin
           mdro = 1; zi = 1;
           alu = (op == 4'h2) ? 4'b0001 : (op == 4'h3) ? 4'b1111 : 4'b0000;
         end else if (is_br) begin zo = 1; pci = 1; dn = 1; end
      6: if (is_alu) begin zo = 1; r1i = 1; dn = 1; end
      default: dn = 1;
    endcase
    return {pco, pci, mar, mdro, iri, yi, zi, zo, so, r1o, r1i, offo, rdd, cy, ci, wm, dn, alu};
  endfunction

  function automatic string step_tag(int s, logic [3:0] op, logic z);
    if (s == 0) return "R2";
    if (s < 3) return "R3";
    if (op inside {4'h1, 4'h2, 4'h3}) return (s == 5) ? "R7" : "R6";
    if (op == 4'h4) return "R8";
    if (op == 4'h5) return "R9";
    return "R10";
  endfunction

  task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step=T%0d opc=%h act=%b exp=%b", tag, m_step + 1, ir_opc, act, exp);
    end
  endtask

  task automatic check_src();
    n_chk++;
    if ($countones({pc_out, mdr_out, z_out, src_out, r1_out, off_out}) > 1) begin
      n_bad++;
      $display("FAIL R12 sources=%b exp=at most one",
               {pc_out, mdr_out, z_out, src_out, r1_out, off_out});
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    string prev_tag;
    logic [20:0] e;
    void'($urandom(32'd4711));
    rst_n = 1'b0; run_en = 1'b1; ir_opc = 4'h1; mfc = 1'b0; zero_flag = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R1", act_vec(), exp_vec(0, ir_opc, zero_flag));
    end
    run_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R4", act_vec(), exp_vec(0, ir_opc, zero_flag));
    end
    prev_tag = "";
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (m_step == 0 && ($urandom % 2 == 0 || cyc < 2)) begin
        ir_opc    = (cyc < 40) ? 4'(1 + (cyc / 8) % 5) : 4'($urandom % 8);
        zero_flag = 1'($urandom);
      end
      run_en = ($urandom % 8) != 0;
      mfc    = 1'($urandom);
      #1;
      e = exp_vec(m_step, ir_opc, zero_flag);
      check(prev_tag != "" ? prev_tag : step_tag(m_step, ir_opc, zero_flag), act_vec(), e);
      check_src();
      prev_tag = "";
      if (!run_en) prev_tag = "R4";
      else if (e[5] && !mfc) prev_tag = "R5";
      else if (e[4]) prev_tag = "R11";
      if (run_en && !(e[5] && !mfc)) m_step = e[4] ? 0 : m_step + 1;
      @(posedge clk);
    end
    finish_run();
  end

endmodule